// File: doc/BRIEF.md
# Sector Slot DMA Scheduler

This block keeps a ring of sixteen sector buffer slots for a CD data DMA engine and decides which one is moved next. Software arms slots by writing a mask into the slot register. A bit that is written as one becomes set, and software cannot clear a bit. The scheduler picks the highest-numbered armed slot. It then raises a block transfer request to the transfer engine with the slot's buffer address, which is the DMA base plus the slot number times 4 KiB.

The engine accepts the request with an acknowledge and later sends a single-cycle done pulse. On that pulse the hardware retires the slot, clears its bit and sets the data-complete interrupt flag. A global data-DMA enable gates the whole scheduler. While it is low the slot register is held at zero, writes to it are lost, and any transfer in flight is abandoned without an interrupt. A small register port gives access to an identifier, the interrupt request word, the interrupt enable word and the slot register.

Top module: `sector_slot_sched`

## Requirements
- R1: Reading word address 0 returns the constant 0xC0CACAFE.
- R2: A write to word address 3 ORs data bits 15:0 into the slot register, and bit n stands for slot n. Zero bits leave set bits unchanged. Reading word 3 returns the slot register in bits 15:0 and zero above.
- R3: Of the armed slots, the highest-numbered is served first and slots are served one at a time. The request address is the DMA base plus slot × 0x1000.
- R4: The request goes high in the second cycle after a write arms an idle scheduler. Request and address are held until the acknowledge is sampled. After that the request stays low until a done pulse arrives.
- R5: The clock edge that samples the done pulse clears the served slot's bit and sets interrupt request bit 26 in word 1.
- R6: Priority is chosen only while idle. A slot armed during a transfer waits until that transfer completes, even if its number is higher. After the completion, the highest remaining slot is chosen.
- R7: A one-cycle command-complete event input sets interrupt request bit 28. Any write to word 3 clears bit 28, including a write of zero, which changes no slot bit.
- R8: While the data-DMA enable is low, the slot register reads zero and writes to it are ignored.
- R9: Dropping the enable during a transfer lowers the request, clears all slot bits and leaves bit 26 unset. A done pulse that arrives later is ignored.
- R10: Word 1 is read-only, so writes to it have no effect. Word 2 is a read/write enable word. The irq output is the OR over all bits of request AND enable. An acknowledge-clear strobe clears bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 identifier, 1 interrupt request, 2 interrupt enable, 3 slot register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| dma_en | input | 1 | Global data-DMA enable |
| dma_base | input | 32 | DMA buffer base address |
| cmd_tx_done | input | 1 | Command transmit complete event, sets request bit 28 |
| data_irq_clr | input | 1 | Acknowledge-clear strobe for request bit 26 |
| xfer_req | output | 1 | Block transfer request |
| xfer_addr | output | 32 | Buffer address of the requested slot |
| xfer_ack | input | 1 | Engine accepts the request |
| xfer_done | input | 1 | Single-cycle block completion pulse |
| irq | output | 1 | Interrupt output |

## Verification
A slot write, a done pulse, an acknowledge, a command event or a clear strobe is registered on the first clock edge. Its effect on the slot register, the interrupt word and the irq output is therefore visible in the cycle after that edge. A new request depends on one more edge, because the idle controller has to see the updated slot register first. So the request for the next slot rises one cycle after the write or completion that enabled it. The bench drives every input on the falling edge and samples on the next falling edge. Each check sits at the cycle the requirement names, and the R4 and R6 checks also look one cycle earlier to confirm the request has not yet risen.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  localparam logic [31:0] ID_WORD = 32'hC0CA_CAFE;
  localparam int DATA_DONE_BIT = 26;
  localparam int CMD_DONE_BIT  = 28;

  localparam logic [1:0] A_ID   = 2'd0;
  localparam logic [1:0] A_IREQ = 2'd1;
  localparam logic [1:0] A_IEN  = 2'd2;
  localparam logic [1:0] A_SLOT = 2'd3;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xfer_state_e;

  // Buffer address of a slot: base plus slot number shifted by the block size.
  function automatic logic [31:0] slot_address(input logic [31:0] base,
                                               input int unsigned idx,
                                               input int unsigned blk_shift);
    logic [31:0] offs;
    offs = 32'(idx) << blk_shift;
    return base + offs;
  endfunction

endpackage

// File: rtl/slot_mask_reg.sv
module slot_mask_reg #(
  parameter int SLOTS = 16,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             set_we,
  input  logic [SLOTS-1:0] set_mask,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic [SLOTS-1:0] slots
);

  logic [SLOTS-1:0] clr_mask;
  logic [SLOTS-1:0] slots_d;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  // Retire first, then arm, so a bit written in the same cycle stays set.
  always_comb begin
    if (!dma_en) slots_d = '0;
    else         slots_d = (slots & ~clr_mask) | (set_we ? set_mask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slots <= '0;
    else        slots <= slots_d;
  end

endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int SLOTS = 16,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] slots,
  output logic             any_armed,
  output logic [IW-1:0]    top_idx
);

  logic [SLOTS-1:0] above;

  // above[i] is set when some slot numbered higher than i is armed.
  assign above[SLOTS-1] = 1'b0;
  for (genvar i = SLOTS - 2; i >= 0; i--) begin : g_above
    assign above[i] = above[i+1] | slots[i+1];
  end

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slots[i] && !above[i]) top_idx = IW'(i);
    end
  end

  assign any_armed = |slots;

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import slot_sched_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          any_armed,
  input  logic [IW-1:0] top_idx,
  input  logic          xfer_ack,
  input  logic          xfer_done,
  output logic          xfer_req,
  output logic [IW-1:0] cur_idx,
  output logic          start_evt,
  output logic          retire_evt
);

  xfer_state_e state, state_d;

  assign start_evt  = (state == XS_IDLE) && dma_en && any_armed;
  assign retire_evt = (state == XS_WAIT) && dma_en && xfer_done;
  assign xfer_req   = (state == XS_REQ);

  always_comb begin
    state_d = state;
    if (!dma_en) begin
      state_d = XS_IDLE;
    end else begin
      unique case (state)
        XS_IDLE: if (any_armed) state_d = XS_REQ;
        XS_REQ:  if (xfer_ack)  state_d = XS_WAIT;
        XS_WAIT: if (xfer_done) state_d = XS_IDLE;
        default: state_d = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      cur_idx <= '0;
    end else begin
      state <= state_d;
      if (start_evt) cur_idx <= top_idx;
    end
  end

endmodule

// File: rtl/irq_block.sv
module irq_block
  import slot_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_set,
  input  logic        data_clr,
  input  logic        cmd_set,
  input  logic        cmd_clr,
  input  logic        en_we,
  input  logic [31:0] en_wdata,
  output logic [31:0] req_word,
  output logic [31:0] en_word,
  output logic        irq
);

  logic data_q, cmd_q;

  // Set takes precedence over clear for both flags.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= 1'b0;
      cmd_q   <= 1'b0;
      en_word <= '0;
    end else begin
      data_q <= data_set | (data_q & ~data_clr);
      cmd_q  <= cmd_set  | (cmd_q  & ~cmd_clr);
      if (en_we) en_word <= en_wdata;
    end
  end

  always_comb begin
    req_word = '0;
    req_word[DATA_DONE_BIT] = data_q;
    req_word[CMD_DONE_BIT]  = cmd_q;
  end

  assign irq = |(req_word & en_word);

endmodule

// File: rtl/sector_slot_sched.sv
module sector_slot_sched
  import slot_sched_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int BLK_SHIFT = 12,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dma_en,
  input  logic [31:0] dma_base,
  input  logic        cmd_tx_done,
  input  logic        data_irq_clr,
  output logic        xfer_req,
  output logic [31:0] xfer_addr,
  input  logic        xfer_ack,
  input  logic        xfer_done,
  output logic        irq
);

  logic [SLOTS-1:0] slot_q;
  logic             any_armed;
  logic [IW-1:0]    sel_idx;
  logic [IW-1:0]    cur_idx;
  logic             start_evt;
  logic             retire_evt;
  logic             slot_wr;
  logic             ien_wr;
  logic [31:0]      ireq_word;
  logic [31:0]      ien_word;

  assign slot_wr = reg_we && (reg_addr == A_SLOT);
  assign ien_wr  = reg_we && (reg_addr == A_IEN);

  slot_mask_reg #(.SLOTS(SLOTS)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en   (dma_en),
    .set_we   (slot_wr),
    .set_mask (reg_wdata[SLOTS-1:0]),
    .clr_en   (retire_evt),
    .clr_idx  (cur_idx),
    .slots    (slot_q)
  );

  slot_pick #(.SLOTS(SLOTS)) u_pick (
    .slots     (slot_q),
    .any_armed (any_armed),
    .top_idx   (sel_idx)
  );

  xfer_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .any_armed  (any_armed),
    .top_idx    (sel_idx),
    .xfer_ack   (xfer_ack),
    .xfer_done  (xfer_done),
    .xfer_req   (xfer_req),
    .cur_idx    (cur_idx),
    .start_evt  (start_evt),
    .retire_evt (retire_evt)
  );

  irq_block u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_set (retire_evt),
    .data_clr (data_irq_clr),
    .cmd_set  (cmd_tx_done),
    .cmd_clr  (slot_wr),
    .en_we    (ien_wr),
    .en_wdata (reg_wdata),
    .req_word (ireq_word),
    .en_word  (ien_word),
    .irq      (irq)
  );

  assign xfer_addr = slot_address(dma_base, int'(cur_idx), BLK_SHIFT);

  always_comb begin
    unique case (reg_addr)
      A_ID:    reg_rdata = ID_WORD;
      A_IREQ:  reg_rdata = ireq_word;
      A_IEN:   reg_rdata = ien_word;
      default: reg_rdata = 32'(slot_q);
    endcase
  end

endmodule

// File: rtl/sector_slot_sched_chk.sv
module sector_slot_sched_chk #(
  parameter int SLOTS = 16,
  localparam int IW = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             dma_en,
  input logic [31:0]      dma_base,
  input logic             cmd_tx_done,
  input logic             xfer_req,
  input logic [31:0]      xfer_addr,
  input logic             xfer_ack,
  input logic [SLOTS-1:0] slots,
  input logic [IW-1:0]    sel_idx,
  input logic             start_evt,
  input logic             retire_evt,
  input logic [31:0]      irq_req
);

  logic        slot_wr;
  logic [31:0] offs;

  assign slot_wr = reg_we && (reg_addr == 2'd3);
  assign offs    = xfer_addr - dma_base;

  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (offs[11:0] == 12'h000 && offs[31:12] < 32'(SLOTS)));

  p_pick_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> ((slots >> sel_idx) == SLOTS'(1)));

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack && dma_en) |=> (xfer_req && $stable(xfer_addr)));

  p_set_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && dma_en && !retire_evt) |=> ((slots & $past(slots)) == $past(slots)));

  p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |=> irq_req[26]);

  p_wr_clr_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && !cmd_tx_done) |=> !irq_req[28]);

  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (slots == '0));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !xfer_req);

endmodule

bind sector_slot_sched sector_slot_sched_chk #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .dma_en      (dma_en),
  .dma_base    (dma_base),
  .cmd_tx_done (cmd_tx_done),
  .xfer_req    (xfer_req),
  .xfer_addr   (xfer_addr),
  .xfer_ack    (xfer_ack),
  .slots       (slot_q),
  .sel_idx     (sel_idx),
  .start_evt   (start_evt),
  .retire_evt  (retire_evt),
  .irq_req     (ireq_word)
);

// File: tb/test_sector_slot_sched.sv
module test_sector_slot_sched;

  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_en = 1'b1;
  logic        cmd_tx_done = 1'b0;
  logic        data_irq_clr = 1'b0;
  logic        xfer_req;
  logic [31:0] xfer_addr;
  logic        xfer_ack = 1'b0;
  logic        xfer_done = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_errs = 0;

  always #4 clk = ~clk;

  sector_slot_sched i_sector_slot_sched (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_en(dma_en),
    .dma_base(BASE), .cmd_tx_done(cmd_tx_done), .data_irq_clr(data_irq_clr),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_ack(xfer_ack),
    .xfer_done(xfer_done), .irq(irq)
  );

  function automatic logic [31:0] exp_addr(input int slot);
    return BASE + slot * 32'h1000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_ack();
    xfer_ack = 1'b1; tick(); xfer_ack = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); check("R10 reset irq request word", d, 32'h0);
    rd(2'd3, d); check("R2 reset slot register", d, 32'h0);
    check("R4 reset request", 32'(xfer_req), 32'h0);
    check("R10 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_id_and_ro();
    logic [31:0] d;
    rd(2'd0, d); check("R1 identifier", d, 32'hC0CA_CAFE);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R10 request word ignores writes", d, 32'h0);
    check("R10 irq after request write", 32'(irq), 32'h0);
  endtask

  task automatic t_arm_and_serve();
    logic [31:0] d;
    wr(2'd3, 32'h0000_0005);
    rd(2'd3, d); check("R2 first arm", d, 32'h5);
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, d); check("R2 zero write keeps bits", d, 32'h5);
    wr(2'd3, 32'h0000_0002);
    rd(2'd3, d); check("R2 set accumulates", d, 32'h7);
    check("R3 request up", 32'(xfer_req), 32'h1);
    check("R3 highest slot address", xfer_addr, exp_addr(2));
    tick(); tick();
    check("R4 request held without ack", 32'(xfer_req), 32'h1);
    check("R4 address held", xfer_addr, exp_addr(2));
    pulse_ack();
    check("R4 request drops after ack", 32'(xfer_req), 32'h0);
    tick(); tick();
    check("R4 waits for done", 32'(xfer_req), 32'h0);
    pulse_done();
    rd(2'd3, d); check("R5 served slot cleared", d, 32'h3);
    rd(2'd1, d); check("R5 data-complete flag", d, 32'h0400_0000);
    check("R3 no request in completion cycle", 32'(xfer_req), 32'h0);
    tick();
    check("R3 next request", 32'(xfer_req), 32'h1);
    check("R3 next slot address", xfer_addr, exp_addr(1));
  endtask

  task automatic t_late_arm();
    logic [31:0] d;
    pulse_ack();
    wr(2'd3, 32'h0000_0200);
    rd(2'd3, d); check("R6 late arm recorded", d, 32'h203);
    tick();
    check("R6 no preemption", 32'(xfer_req), 32'h0);
    pulse_done();
    rd(2'd3, d); check("R6 slot 1 retired", d, 32'h201);
    tick();
    check("R6 request after completion", 32'(xfer_req), 32'h1);
    check("R6 picks slot 9", xfer_addr, exp_addr(9));
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(2'd2, 32'h0400_0000);
    rd(2'd2, d); check("R10 enable word readback", d, 32'h0400_0000);
    check("R10 irq from data flag", 32'(irq), 32'h1);
    data_irq_clr = 1'b1; tick(); data_irq_clr = 1'b0;
    rd(2'd1, d); check("R10 ack clears bit 26", d, 32'h0);
    check("R10 irq low after clear", 32'(irq), 32'h0);
    cmd_tx_done = 1'b1; tick(); cmd_tx_done = 1'b0;
    rd(2'd1, d); check("R7 command flag set", d, 32'h1000_0000);
    check("R10 masked command flag", 32'(irq), 32'h0);
    wr(2'd2, 32'h1400_0000);
    check("R10 irq from command flag", 32'(irq), 32'h1);
    wr(2'd3, 32'h0000_0000);
    rd(2'd1, d); check("R7 slot write clears bit 28", d, 32'h0);
    check("R7 irq low", 32'(irq), 32'h0);
    rd(2'd3, d); check("R7 zero write leaves slots", d, 32'h201);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    pulse_ack();
    dma_en = 1'b0;
    tick();
    check("R9 request abandoned", 32'(xfer_req), 32'h0);
    rd(2'd3, d); check("R9 slots cleared", d, 32'h0);
    pulse_done();
    rd(2'd1, d); check("R9 no completion flag", d, 32'h0);
    check("R9 irq stays low", 32'(irq), 32'h0);
    wr(2'd3, 32'h0000_FFFF);
    rd(2'd3, d); check("R8 write ignored while disabled", d, 32'h0);
    tick();
    check("R8 no request while disabled", 32'(xfer_req), 32'h0);
    dma_en = 1'b1;
    tick(); tick();
    rd(2'd3, d); check("R8 empty after re-enable", d, 32'h0);
    check("R8 idle after re-enable", 32'(xfer_req), 32'h0);
  endtask

  task automatic t_drain();
    logic [31:0] d;
    wr(2'd3, 32'h0000_8001);
    check("R4 request not yet up", 32'(xfer_req), 32'h0);
    tick();
    check("R4 request second cycle", 32'(xfer_req), 32'h1);
    check("R3 slot 15 first", xfer_addr, exp_addr(15));
    pulse_ack(); pulse_done();
    rd(2'd3, d); check("R5 slot 15 retired", d, 32'h1);
    tick();
    check("R3 slot 0 address", xfer_addr, exp_addr(0));
    pulse_ack(); pulse_done();
    rd(2'd3, d); check("R5 all retired", d, 32'h0);
    tick();
    check("R3 idle when empty", 32'(xfer_req), 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_id_and_ro();
    t_arm_and_serve();
    t_late_arm();
    t_irq();
    t_disable();
    t_drain();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule